// File: doc/BRIEF.md
# PHY Power Sequencing Controller

This block brings the analog section of a storage-card PHY up or down in a fixed order. A request carries a direction (up or down) and the current card clock rate in Hz. Every request first forces the analog power control and the DLL enable low. A power-down request ends there. A power-up request continues through these steps:

- it picks a DLL frequency band from the rate;
- it holds power off for a settling interval;
- it raises power and polls the calibration status with a short timeout;
- it applies the band and then enables the DLL;
- it polls the DLL lock status with a long timeout.

The DLL lock poll is skipped when the rate is zero, because a DLL with no clock never locks.

All waits count a one-microsecond tick supplied from outside, so the timing does not depend on the system clock frequency. The two status inputs pass through a two-flop synchronizer before the state machine samples them. `busy` is high while a sequence runs. When a sequence ends, `done` or `err` goes high and stays high until the next request is accepted. `err_code` records which poll timed out.

Top module: `phy_pwr_seq`

## Requirements
- R1: An accepted request drives `pwr_on` and `dll_en` low and raises `busy`. A power-down request (`req_on`=0) then ends with `done`=1, `err`=0, and `pwr_on` never rises.
- R2: On power-up, `band` is set from the rate as follows: 1 to 74,999,999 Hz gives code 1 (50 MHz), 75,000,000 to 124,999,999 Hz gives code 2 (100 MHz), 125,000,000 to 174,999,999 Hz gives code 3 (150 MHz), and zero or 175,000,000 Hz and above gives code 0 (200 MHz).
- R3: On power-up, `rate_warn` is 1 in either of two cases: the rate is above 200,000,000 Hz, or the rate is above 50,000,000 Hz and differs from the selected band's nominal frequency by more than 15,000,000 Hz. Otherwise it is 0.
- R4: On power-up, `pwr_on` rises only after at least PRE_US ticks have been seen while `busy` is high and power is off.
- R5: After `pwr_on` rises, calibration done is awaited for CAL_US ticks. Calibration arriving within that window lets the sequence continue. If it never arrives, the sequence ends with `err`=1, `err_code`=1, `dll_en`=0 and `pwr_on`=1.
- R6: `dll_en` rises only after calibration is done, only while `pwr_on` is high, and only in a cycle after `band` already holds its new value.
- R7: With a rate of zero, the sequence ends with `done`=1 and `dll_en`=1 without waiting for DLL ready.
- R8: With a nonzero rate, DLL ready is awaited for LOCK_US ticks. If it never arrives, the sequence ends with `err`=1, `err_code`=2 and `dll_en`=1. If it arrives, the sequence ends with `done`=1 and `err_code`=0.
- R9: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_on | input | 1 | 1 = power up, 0 = power down |
| rate_hz | input | RATE_W | Card clock rate in Hz |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cal_done_in | input | 1 | Asynchronous calibration-done status |
| dll_rdy_in | input | 1 | Asynchronous DLL-ready status |
| pwr_on | output | 1 | Analog power-on control |
| dll_en | output | 1 | DLL enable |
| band | output | 2 | DLL frequency band code |
| rate_warn | output | 1 | Rate out of the accurate range |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence finished successfully |
| err | output | 1 | Last sequence timed out |
| err_code | output | 2 | 0 none, 1 calibration timeout, 2 lock timeout |

## Verification
The bench builds the block with PRE_US=3, CAL_US=10 and LOCK_US=40, and it ticks every four clock cycles. The short lock window lets the bench reach the DLL-lock timeout, which with the default of 50,000 ticks would be far out of reach. Calibration timeout, late calibration and a request arriving during a lock wait all complete in a few hundred cycles. The rate points sit on and around every band edge, so each branch of the warning rule is exercised.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int RATE_W  = 32,
  parameter int PRE_US  = 3,
  parameter int CAL_US  = 50,
  parameter int LOCK_US = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic [RATE_W-1:0] rate_hz,
  input  logic              us_tick,
  input  logic              cal_done_in,
  input  logic              dll_rdy_in,
  output logic              pwr_on,
  output logic              dll_en,
  output logic [1:0]        band,
  output logic              rate_warn,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);
  localparam int MAXU  = (LOCK_US > CAL_US) ? ((LOCK_US > PRE_US) ? LOCK_US : PRE_US)
                                            : ((CAL_US > PRE_US) ? CAL_US : PRE_US);
  localparam int CNT_W = $clog2(MAXU + 2);

  typedef enum logic [2:0] {S_IDLE, S_OFF, S_PRE, S_CAL, S_BAND, S_DLL, S_LOCK} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt;
  logic [1:0]       cal_sy, dll_sy;
  logic             is_on, rate_zero;
  logic [1:0]       band_p;
  logic [63:0]      r, nom, diff;
  logic [1:0]       band_c;
  logic             warn_c;

  assign r = 64'(rate_hz);

  always_comb begin
    if (r == 64'd0)                 begin band_c = 2'd0; nom = 64'd200_000_000; end
    else if (r < 64'd75_000_000)    begin band_c = 2'd1; nom = 64'd50_000_000;  end
    else if (r < 64'd125_000_000)   begin band_c = 2'd2; nom = 64'd100_000_000; end
    else if (r < 64'd175_000_000)   begin band_c = 2'd3; nom = 64'd150_000_000; end
    else                            begin band_c = 2'd0; nom = 64'd200_000_000; end
    diff   = (r > nom) ? r - nom : nom - r;
    warn_c = (r > 64'd200_000_000) || ((r > 64'd50_000_000) && (diff > 64'd15_000_000));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_sy <= '0;
      dll_sy <= '0;
    end else begin
      cal_sy <= {cal_sy[0], cal_done_in};
      dll_sy <= {dll_sy[0], dll_rdy_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; is_on <= 1'b0; rate_zero <= 1'b0; band_p <= '0;
      pwr_on <= 1'b0; dll_en <= 1'b0; band <= '0; rate_warn <= 1'b0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; err_code <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          busy <= 1'b1; done <= 1'b0; err <= 1'b0; err_code <= '0;
          pwr_on <= 1'b0; dll_en <= 1'b0;
          is_on <= req_on; rate_zero <= (r == 64'd0); band_p <= band_c;
          if (req_on) rate_warn <= warn_c;
          st <= S_OFF;
        end
        S_OFF: begin
          cnt <= '0;
          if (is_on) st <= S_PRE;
          else begin busy <= 1'b0; done <= 1'b1; st <= S_IDLE; end
        end
        S_PRE: if (us_tick) begin
          if (cnt == CNT_W'(PRE_US)) begin
            pwr_on <= 1'b1; cnt <= '0; st <= S_CAL;
          end else cnt <= cnt + 1'b1;
        end
        S_CAL: begin
          if (cal_sy[1]) st <= S_BAND;
          else if (us_tick) begin
            if (cnt == CNT_W'(CAL_US - 1)) begin
              busy <= 1'b0; err <= 1'b1; err_code <= 2'd1; st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_BAND: begin
          band <= band_p; st <= S_DLL;
        end
        S_DLL: begin
          dll_en <= 1'b1; cnt <= '0;
          if (rate_zero) begin busy <= 1'b0; done <= 1'b1; st <= S_IDLE; end
          else st <= S_LOCK;
        end
        S_LOCK: begin
          if (dll_sy[1]) begin busy <= 1'b0; done <= 1'b1; st <= S_IDLE; end
          else if (us_tick) begin
            if (cnt == CNT_W'(LOCK_US - 1)) begin
              busy <= 1'b0; err <= 1'b1; err_code <= 2'd2; st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
  parameter int PRE_US = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       us_tick,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       pwr_on,
  input logic       dll_en,
  input logic [1:0] band
);
  logic        busy_q;
  logic [15:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pre_cnt <= '0;
    end else begin
      busy_q <= busy;
      if (busy && !busy_q) pre_cnt <= '0;
      else if (busy && !pwr_on && us_tick && pre_cnt != 16'hffff) pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_START_LOW:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (!pwr_on && !dll_en)); // R1
  AST_PRE_WAIT:    assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_on) |-> (32'(pre_cnt) >= PRE_US)); // R4
  AST_DLL_PWR:     assert property (@(posedge clk) disable iff (!rst_n) dll_en |-> pwr_on); // R6
  AST_BAND_FIRST:  assert property (@(posedge clk) disable iff (!rst_n) $rose(dll_en) |-> $stable(band)); // R6
  AST_END_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0({busy, done, err})); // R9
  AST_ERR_CODE:    assert property (@(posedge clk) disable iff (!rst_n) err |-> (err_code != 2'd0)); // R8
  AST_DONE_CODE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (err_code == 2'd0)); // R8
  AST_CAL_ERR_DLL: assert property (@(posedge clk) disable iff (!rst_n) (err && err_code == 2'd1) |-> !dll_en); // R5
endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.PRE_US(PRE_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .busy(busy), .done(done), .err(err),
  .err_code(err_code), .pwr_on(pwr_on), .dll_en(dll_en), .band(band)
);

// File: tb/sim_phy_pwr_seq.sv
`timescale 1ns/1ps
module sim_phy_pwr_seq;
  localparam int PRE = 3, CAL = 10, LCK = 40;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_on = 0, us_tick = 0, cal_done_in = 0, dll_rdy_in = 0;
  logic [31:0] rate_hz = 0;
  logic        pwr_on, dll_en, rate_warn, busy, done, err;
  logic [1:0]  band, err_code;

  int total = 0, bad = 0;
  int pre_ticks;
  bit saw_pwr, en_bad;
  logic [1:0] band_at_en;

  phy_pwr_seq #(.RATE_W(32), .PRE_US(PRE), .CAL_US(CAL), .LOCK_US(LCK)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on), .rate_hz(rate_hz),
    .us_tick(us_tick), .cal_done_in(cal_done_in), .dll_rdy_in(dll_rdy_in),
    .pwr_on(pwr_on), .dll_en(dll_en), .band(band), .rate_warn(rate_warn),
    .busy(busy), .done(done), .err(err), .err_code(err_code));

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 us_tick = 1;
      @(posedge clk);
      #1 us_tick = 0;
    end
  end

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_band(logic [31:0] r);
    if (r == 0) return 2'd0;
    if (r < 75_000_000) return 2'd1;
    if (r < 125_000_000) return 2'd2;
    if (r < 175_000_000) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic exp_warn(logic [31:0] r);
    longint n, d;
    case (exp_band(r))
      2'd1: n = 50_000_000;
      2'd2: n = 100_000_000;
      2'd3: n = 150_000_000;
      default: n = 200_000_000;
    endcase
    d = (longint'(r) > n) ? longint'(r) - n : n - longint'(r);
    return (r > 200_000_000) || (r > 50_000_000 && d > 15_000_000);
  endfunction

  task automatic issue(bit on, logic [31:0] r);
    @(negedge clk);
    req_valid = 1; req_on = on; rate_hz = r;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_wait();
    int cyc = 0;
    bit first = 1;
    logic [1:0] prev = band;
    pre_ticks = 0; saw_pwr = 0; en_bad = 0; band_at_en = 2'bxx;
    while (!(done || err) && cyc < 3000) begin
      if (busy && !pwr_on && us_tick) pre_ticks++;
      if (pwr_on) saw_pwr = 1;
      if (dll_en && !pwr_on) en_bad = 1;
      if (dll_en && first) begin band_at_en = prev; first = 0; end
      prev = band;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk("R1 reset pwr_on", pwr_on, 0);
    chk("R1 reset dll_en", dll_en, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done/err", {done, err}, 0);
  endtask

  task automatic t_up(logic [31:0] r);
    cal_done_in = 1; dll_rdy_in = 1;
    issue(1, r);
    chk("R1 busy after request", busy, 1);
    finish_wait();
    chk("R8 done", {done, err, err_code}, 4'b1000);
    chk("R2 band", band, exp_band(r));
    chk("R3 rate_warn", rate_warn, exp_warn(r));
    chk("R4 pre ticks >= PRE", pre_ticks >= PRE, 1);
    chk("R6 band set before dll_en", band_at_en, exp_band(r));
    chk("R6 dll_en only with power", en_bad, 0);
  endtask

  task automatic t_off();
    issue(0, 32'd100_000_000);
    finish_wait();
    chk("R1 off done", {done, err}, 2'b10);
    chk("R1 off pwr never rose", saw_pwr, 0);
    chk("R1 off outputs low", {pwr_on, dll_en}, 0);
  endtask

  task automatic t_cal_timeout();
    cal_done_in = 0; dll_rdy_in = 1;
    issue(1, 32'd100_000_000);
    finish_wait();
    chk("R5 cal timeout err", {err, err_code}, 3'b101);
    chk("R5 cal timeout dll_en", dll_en, 0);
    chk("R5 cal timeout pwr_on", pwr_on, 1);
  endtask

  task automatic t_cal_late();
    cal_done_in = 0; dll_rdy_in = 1;
    issue(1, 32'd150_000_000);
    while (!pwr_on) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R6 no dll_en before cal", dll_en, 0);
    cal_done_in = 1;
    finish_wait();
    chk("R5 late cal succeeds", {done, err}, 2'b10);
    chk("R2 band after late cal", band, 2'd3);
  endtask

  task automatic t_zero();
    cal_done_in = 1; dll_rdy_in = 0;
    issue(1, 32'd0);
    finish_wait();
    chk("R7 zero rate done", {done, err}, 2'b10);
    chk("R7 zero rate dll_en", dll_en, 1);
    chk("R2 zero rate band", band, 2'd0);
    chk("R3 zero rate warn", rate_warn, 0);
  endtask

  task automatic t_lock_timeout();
    cal_done_in = 1; dll_rdy_in = 0;
    issue(1, 32'd100_000_000);
    finish_wait();
    chk("R8 lock timeout err", {err, err_code}, 3'b110);
    chk("R8 lock timeout dll_en", dll_en, 1);
  endtask

  task automatic t_ignore();
    cal_done_in = 1; dll_rdy_in = 0;
    issue(1, 32'd100_000_000);
    while (!dll_en) @(negedge clk);
    issue(0, 32'd30_000_000);
    repeat (4) @(negedge clk);
    chk("R9 power kept during busy", pwr_on, 1);
    chk("R9 still busy", busy, 1);
    dll_rdy_in = 1;
    finish_wait();
    chk("R9 ignored request: done", {done, err}, 2'b10);
    chk("R9 ignored request: band", band, 2'd2);
    chk("R9 ignored request: pwr_on", pwr_on, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_up(32'd30_000_000);
    t_up(32'd50_000_000);
    t_up(32'd70_000_000);
    t_up(32'd74_999_999);
    t_up(32'd80_000_000);
    t_up(32'd100_000_000);
    t_up(32'd124_999_999);
    t_up(32'd125_000_000);
    t_up(32'd150_000_000);
    t_up(32'd175_000_000);
    t_up(32'd200_000_000);
    t_up(32'd210_000_000);
    t_off();
    t_cal_timeout();
    t_cal_late();
    t_zero();
    t_lock_timeout();
    t_ignore();
    t_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule